// File: doc/BRIEF.md
# RV64 Integer Execute and Branch Stage

This block is the execute stage of a 64-bit base-integer RISC-style core. Each cycle it may accept one 32-bit instruction word with the two 64-bit source register values and the program counter of that instruction. From these it builds the sign-extended immediate of the instruction's format and computes one of the following:

- an arithmetic result (register add, add-immediate, 32-bit word add, load-upper constant);
- a store address;
- a branch or jump target with its taken decision.

There are no condition flags. A branch decides by comparing its two register operands directly in the same cycle.

Every output comes from a single register stage, so each result appears one clock after its instruction is presented. Writeback is never requested for destination register zero. Opcodes and function codes outside the supported set raise an illegal flag. An illegal instruction neither writes back nor redirects the fetch. The register file, fetch, memory access and multiply/divide lie outside this block.

Top module: `rv_exec_unit`

## Requirements
- R1: Add-immediate (opcode 0010011, funct3 000) adds rs1 to the 12-bit signed immediate in bits 31:20, sign-extended to 64 bits. The range is -2048 to +2047, so 0xEEF counts as -273.
- R2: Store (opcode 0100011, funct3 000 to 011) returns rs1 plus a 12-bit signed immediate with bits 11:5 taken from instruction bits 31:25 and bits 4:0 from bits 11:7. It never asserts writeback.
- R3: Conditional branch (opcode 1100011) gives target = pc + offset. The offset is {b31, b7, b30:25, b11:8, 0}, sign-extended, so it is even and spans -4096 to +4094.
- R4: Jump-and-link (opcode 1101111) gives target = pc + {b31, b19:12, b20, b30:21, 0} sign-extended (about ±1 MiB), result = pc + 4, and always asserts taken.
- R5: Load-upper (opcode 0110111) returns bits 31:12 of the instruction in result bits 31:12, with zeros below and bit 31 copied into bits 63:32.
- R6: Register add (opcode 0110011, funct3 000, funct7 0) wraps at 64 bits. Word add (opcode 0111011, funct3 000, funct7 0) adds the low 32 bits modulo 2^32 and copies bit 31 into bits 63:32.
- R7: The branch taken flag follows funct3 on rs1 and rs2:
  - 000: equal
  - 001: not equal
  - 100: signed less than
  - 101: signed greater or equal
  - 110: unsigned less than
  - 111: unsigned greater or equal
- R8: Writeback is asserted only for a legal add, add-immediate, word add, load-upper or jump-and-link whose rd (bits 11:7) is not zero. With rd = 0, jump-and-link still reports taken.
- R9: Any other opcode, a branch funct3 of 010 or 011, or a nonzero funct7 or funct3 on the add forms raises illegal. An illegal instruction keeps writeback and taken low.
- R10: All outputs are registered, so a result appears one rising edge after its inputs. Synchronous active-high reset clears valid, taken, writeback and illegal. An input cycle with in_valid low yields out_valid, taken, writeback and illegal all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | 64 | First source register value |
| rs2_val | input | 64 | Second source register value |
| pc | input | 64 | Address of the instruction |
| out_valid | output | 1 | Registered results belong to a presented instruction |
| wb_en | output | 1 | Request to write result to rd_idx |
| rd_idx | output | 5 | Destination register index |
| result | output | 64 | Arithmetic result, link address or store address |
| target | output | 64 | Branch or jump target |
| taken | output | 1 | Control transfer to target is required |
| illegal | output | 1 | Instruction not supported |

## Verification
Two functions can meet in one cycle: writeback suppression for register zero and the control transfer of a jump-and-link. The bench provokes this with a jump whose rd is x0. It expects taken high, the computed target and pc+4 in result, and writeback low. It also pairs the illegal path with a branch whose funct3 is unassigned, even though the two operands would satisfy a real comparison. There, taken must stay low while illegal rises.

// File: rtl/rvx_pkg.sv
package rvx_pkg;

    typedef enum logic [6:0] {
        OPC_REG    = 7'b0110011,
        OPC_IMM    = 7'b0010011,
        OPC_REGW   = 7'b0111011,
        OPC_UPPER  = 7'b0110111,
        OPC_STORE  = 7'b0100011,
        OPC_BRANCH = 7'b1100011,
        OPC_JUMP   = 7'b1101111
    } opcode_e;

    localparam int unsigned ILEN   = 32;
    localparam int unsigned RIDX_W = 5;

endpackage

// File: rtl/rvx_imm_builder.sv
module rvx_imm_builder #(
    parameter int unsigned XLEN = 64
) (
    input  logic [31:7]     ibits,
    output logic [XLEN-1:0] imm_i,
    output logic [XLEN-1:0] imm_s,
    output logic [XLEN-1:0] imm_b,
    output logic [XLEN-1:0] imm_u,
    output logic [XLEN-1:0] imm_j
);
    localparam int unsigned EXT12 = XLEN - 12;
    localparam int unsigned EXT13 = XLEN - 13;
    localparam int unsigned EXT21 = XLEN - 21;
    localparam int unsigned EXT32 = XLEN - 32;

    logic sgn;

    always_comb begin
        sgn   = ibits[31];
        imm_i = {{EXT12{sgn}}, ibits[31:20]};
        imm_s = {{EXT12{sgn}}, ibits[31:25], ibits[11:7]};
        imm_b = {{EXT13{sgn}}, sgn, ibits[7], ibits[30:25], ibits[11:8], 1'b0};
        imm_u = {{EXT32{sgn}}, ibits[31:12], 12'b0};
        imm_j = {{EXT21{sgn}}, sgn, ibits[19:12], ibits[20], ibits[30:21], 1'b0};
    end

endmodule

// File: rtl/rvx_adder.sv
module rvx_adder #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            word,
    output logic [XLEN-1:0] sum
);
    localparam int unsigned HI_W = XLEN - 32;

    logic [XLEN-1:0] full_sum;
    logic [31:0]     low_sum;

    always_comb begin
        full_sum = opa + opb;
        low_sum  = opa[31:0] + opb[31:0];
        sum      = word ? {{HI_W{low_sum[31]}}, low_sum} : full_sum;
    end

endmodule

// File: rtl/rvx_branch_cmp.sv
module rvx_branch_cmp #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  logic [2:0]      cond,
    output logic            take,
    output logic            cond_ok
);
    logic eq, lt_s, lt_u;

    always_comb begin
        eq      = (lhs == rhs);
        lt_s    = ($signed(lhs) < $signed(rhs));
        lt_u    = (lhs < rhs);
        cond_ok = 1'b1;
        unique case (cond)
            3'b000:  take = eq;
            3'b001:  take = !eq;
            3'b100:  take = lt_s;
            3'b101:  take = !lt_s;
            3'b110:  take = lt_u;
            3'b111:  take = !lt_u;
            default: begin
                take    = 1'b0;
                cond_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rv_exec_unit.sv
module rv_exec_unit
    import rvx_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [ILEN-1:0]     instr,
    input  logic [XLEN-1:0]     rs1_val,
    input  logic [XLEN-1:0]     rs2_val,
    input  logic [XLEN-1:0]     pc,
    output logic                out_valid,
    output logic                wb_en,
    output logic [RIDX_W-1:0]   rd_idx,
    output logic [XLEN-1:0]     result,
    output logic [XLEN-1:0]     target,
    output logic                taken,
    output logic                illegal
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    typedef struct packed {
        logic              valid;
        logic              wb;
        logic [RIDX_W-1:0] rd;
        logic [XLEN-1:0]   res;
        logic [XLEN-1:0]   tgt;
        logic              tkn;
        logic              ill;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [6:0]        op;
    logic [2:0]        f3;
    logic [6:0]        f7;
    logic [RIDX_W-1:0] rd;
    logic              rd_nz;

    logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;
    logic [XLEN-1:0] alu_a, alu_b, alu_sum, tgt_off, tgt_sum;
    logic            alu_word;
    logic            br_take, br_ok;

    assign op    = instr[6:0];
    assign f3    = instr[14:12];
    assign f7    = instr[31:25];
    assign rd    = instr[11:7];
    assign rd_nz = (rd != '0);

    rvx_imm_builder #(.XLEN(XLEN)) u_imm (
        .ibits (instr[31:7]),
        .imm_i (imm_i),
        .imm_s (imm_s),
        .imm_b (imm_b),
        .imm_u (imm_u),
        .imm_j (imm_j)
    );

    always_comb begin
        alu_a    = rs1_val;
        alu_b    = rs2_val;
        alu_word = 1'b0;
        unique case (op)
            OPC_IMM:   alu_b    = imm_i;
            OPC_STORE: alu_b    = imm_s;
            OPC_REGW:  alu_word = 1'b1;
            default:   ;
        endcase
        tgt_off = (op == OPC_JUMP) ? imm_j : imm_b;
    end

    rvx_adder #(.XLEN(XLEN)) u_alu (
        .opa  (alu_a),
        .opb  (alu_b),
        .word (alu_word),
        .sum  (alu_sum)
    );

    rvx_adder #(.XLEN(XLEN)) u_tgt (
        .opa  (pc),
        .opb  (tgt_off),
        .word (1'b0),
        .sum  (tgt_sum)
    );

    rvx_branch_cmp #(.XLEN(XLEN)) u_cmp (
        .lhs     (rs1_val),
        .rhs     (rs2_val),
        .cond    (f3),
        .take    (br_take),
        .cond_ok (br_ok)
    );

    always_comb begin
        stage_d       = '0;
        stage_d.valid = in_valid;
        stage_d.rd    = rd;
        if (in_valid) begin
            unique case (op)
                OPC_REG, OPC_REGW: begin
                    if (f3 == 3'b000 && f7 == 7'b0) begin
                        stage_d.res = alu_sum;
                        stage_d.wb  = rd_nz;
                    end else begin
                        stage_d.ill = 1'b1;
                    end
                end
                OPC_IMM: begin
                    if (f3 == 3'b000) begin
                        stage_d.res = alu_sum;
                        stage_d.wb  = rd_nz;
                    end else begin
                        stage_d.ill = 1'b1;
                    end
                end
                OPC_UPPER: begin
                    stage_d.res = imm_u;
                    stage_d.wb  = rd_nz;
                end
                OPC_STORE: begin
                    if (!f3[2]) stage_d.res = alu_sum;
                    else        stage_d.ill = 1'b1;
                end
                OPC_BRANCH: begin
                    if (br_ok) begin
                        stage_d.tgt = tgt_sum;
                        stage_d.tkn = br_take;
                    end else begin
                        stage_d.ill = 1'b1;
                    end
                end
                OPC_JUMP: begin
                    stage_d.res = pc + STEP;
                    stage_d.tgt = tgt_sum;
                    stage_d.tkn = 1'b1;
                    stage_d.wb  = rd_nz;
                end
                default: stage_d.ill = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assign out_valid = stage_q.valid;
    assign wb_en     = stage_q.wb;
    assign rd_idx    = stage_q.rd;
    assign result    = stage_q.res;
    assign target    = stage_q.tgt;
    assign taken     = stage_q.tkn;
    assign illegal   = stage_q.ill;

    // R8
    rd_zero_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[11:7] == 5'd0) |=> !wb_en);

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!wb_en && !taken));

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !taken && !wb_en));

    // R4
    jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[6:0] == 7'b1101111) |=> taken);

    // R3
    target_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[6:0] == 7'b1100011) |=> (target[0] == $past(pc[0])));

endmodule

// File: tb/sim_rv_exec_unit.sv
module sim_rv_exec_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] rs1_val, rs2_val, pc;
    logic        out_valid, wb_en, taken, illegal;
    logic [4:0]  rd_idx;
    logic [63:0] result, target;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rv_exec_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .pc(pc),
        .out_valid(out_valid), .wb_en(wb_en), .rd_idx(rd_idx),
        .result(result), .target(target), .taken(taken), .illegal(illegal)
    );

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd, input logic [6:0] op);
        return {f7, rs2, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [2:0] f3);
        return {imm[11:5], 5'd2, 5'd1, f3, imm[4:0], 7'b0100011};
    endfunction

    function automatic logic [31:0] enc_b(input logic [12:0] o, input logic [2:0] f3);
        return {o[12], o[10:5], 5'd2, 5'd1, f3, o[4:1], o[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_j(input logic [20:0] o, input logic [4:0] rd);
        return {o[20], o[10:1], o[11], o[19:12], rd, 7'b1101111};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [31:0] ins, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] p);
        @(negedge clk);
        in_valid = v; instr = ins; rs1_val = a; rs2_val = b; pc = p;
        @(posedge clk);
        #2;
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10", "valid after reset", {63'b0, out_valid}, 64'd0);
        chk("R10", "taken after reset", {63'b0, taken}, 64'd0);
        chk("R10", "wb after reset", {63'b0, wb_en}, 64'd0);
    endtask

    task automatic t_addi;
        issue(1, enc_i(12'hEEF, 5'd3, 3'b000, 5'd5, 7'b0010011), 64'd1000, 0, 0);
        chk("R1", "addi 0xEEF", result, 64'd727);
        chk("R10", "valid one edge later", {63'b0, out_valid}, 64'd1);
        chk("R8", "wb rd5", {63'b0, wb_en}, 64'd1);
        chk("R8", "rd index", {59'b0, rd_idx}, 64'd5);
        issue(1, enc_i(12'h7FF, 5'd3, 3'b000, 5'd5, 7'b0010011), 64'd0, 0, 0);
        chk("R1", "addi max", result, 64'd2047);
        issue(1, enc_i(12'h800, 5'd3, 3'b000, 5'd5, 7'b0010011), 64'd0, 0, 0);
        chk("R1", "addi min", result, -64'sd2048);
    endtask

    task automatic t_store;
        issue(1, enc_s(12'hFEC, 3'b011), 64'h1000, 64'h55, 0);
        chk("R2", "store addr -20", result, 64'hFEC);
        chk("R2", "store no wb", {63'b0, wb_en}, 64'd0);
        issue(1, enc_s(12'h7E1, 3'b000), 64'h1000, 0, 0);
        chk("R2", "store addr +2017", result, 64'h1000 + 64'd2017);
    endtask

    task automatic t_branch;
        issue(1, enc_b(13'h1000, 3'b000), 64'd7, 64'd7, 64'h2000);
        chk("R3", "branch -4096", target, 64'h1000);
        chk("R7", "beq equal", {63'b0, taken}, 64'd1);
        issue(1, enc_b(13'h0FFE, 3'b001), 64'd7, 64'd7, 64'h2000);
        chk("R3", "branch +4094", target, 64'h2FFE);
        chk("R7", "bne equal", {63'b0, taken}, 64'd0);
        issue(1, enc_b(13'd2, 3'b100), -64'sd1, 64'd1, 64'h2000);
        chk("R3", "branch +2", target, 64'h2002);
        chk("R7", "blt -1<1", {63'b0, taken}, 64'd1);
        issue(1, enc_b(13'd2, 3'b110), -64'sd1, 64'd1, 64'h2000);
        chk("R7", "bltu big<1", {63'b0, taken}, 64'd0);
        issue(1, enc_b(13'd2, 3'b101), -64'sd1, 64'd1, 64'h2000);
        chk("R7", "bge -1>=1", {63'b0, taken}, 64'd0);
        issue(1, enc_b(13'd2, 3'b111), -64'sd1, 64'd1, 64'h2000);
        chk("R7", "bgeu big>=1", {63'b0, taken}, 64'd1);
        chk("R8", "branch no wb", {63'b0, wb_en}, 64'd0);
    endtask

    task automatic t_jump;
        issue(1, enc_j(21'h100000, 5'd1), 0, 0, 64'h200000);
        chk("R4", "jal -1MiB", target, 64'h100000);
        chk("R4", "jal link", result, 64'h200004);
        chk("R4", "jal taken", {63'b0, taken}, 64'd1);
        chk("R8", "jal wb rd1", {63'b0, wb_en}, 64'd1);
        issue(1, enc_j(21'd2, 5'd0), 0, 0, 64'h40);
        chk("R4", "jal +2", target, 64'h42);
        chk("R4", "jal x0 taken", {63'b0, taken}, 64'd1);
        chk("R8", "jal x0 no wb", {63'b0, wb_en}, 64'd0);
    endtask

    task automatic t_upper;
        issue(1, {20'hDEADC, 5'd10, 7'b0110111}, 0, 0, 0);
        chk("R5", "lui sign", result, 64'hFFFF_FFFF_DEAD_C000);
        issue(1, enc_i(12'hEEF, 5'd10, 3'b000, 5'd10, 7'b0010011), 64'hFFFF_FFFF_DEAD_C000, 0, 0);
        chk("R1", "lui+addi", result, 64'hFFFF_FFFF_DEAD_BEEF);
        issue(1, {20'h12345, 5'd10, 7'b0110111}, 0, 0, 0);
        chk("R5", "lui positive", result, 64'h1234_5000);
    endtask

    task automatic t_add;
        issue(1, enc_r(7'd0, 5'd2, 5'd1, 3'b000, 5'd4, 7'b0110011), 64'h7FFF_FFFF, 64'd1, 0);
        chk("R6", "add no 32 wrap", result, 64'h8000_0000);
        issue(1, enc_r(7'd0, 5'd2, 5'd1, 3'b000, 5'd4, 7'b0111011), 64'h7FFF_FFFF, 64'd1, 0);
        chk("R6", "addw wrap", result, 64'hFFFF_FFFF_8000_0000);
        issue(1, enc_r(7'd0, 5'd2, 5'd1, 3'b000, 5'd4, 7'b0111011), 64'hAAAA_0000_FFFF_FFFF, 64'd2, 0);
        chk("R6", "addw ignores upper", result, 64'd1);
        issue(1, enc_r(7'd0, 5'd2, 5'd1, 3'b000, 5'd4, 7'b0110011), -64'sd1, 64'd2, 0);
        chk("R6", "add 64 wrap", result, 64'd1);
    endtask

    task automatic t_zero_dest;
        issue(1, enc_i(12'd0, 5'd0, 3'b000, 5'd0, 7'b0010011), 0, 0, 0);
        chk("R8", "nop valid", {63'b0, out_valid}, 64'd1);
        chk("R8", "nop no wb", {63'b0, wb_en}, 64'd0);
        issue(1, {20'hFFFFF, 5'd0, 7'b0110111}, 0, 0, 0);
        chk("R8", "lui x0 no wb", {63'b0, wb_en}, 64'd0);
    endtask

    task automatic t_illegal;
        issue(1, enc_i(12'd0, 5'd1, 3'b011, 5'd7, 7'b0000011), 0, 0, 0);
        chk("R9", "load illegal", {63'b0, illegal}, 64'd1);
        chk("R9", "load no wb", {63'b0, wb_en}, 64'd0);
        issue(1, enc_r(7'b0100000, 5'd2, 5'd1, 3'b000, 5'd4, 7'b0110011), 5, 3, 0);
        chk("R9", "funct7 illegal", {63'b0, illegal}, 64'd1);
        chk("R9", "funct7 no wb", {63'b0, wb_en}, 64'd0);
        issue(1, enc_b(13'd8, 3'b010), 64'd3, 64'd3, 64'h100);
        chk("R9", "branch f3 010 illegal", {63'b0, illegal}, 64'd1);
        chk("R9", "branch f3 010 not taken", {63'b0, taken}, 64'd0);
        issue(1, enc_i(12'd1, 5'd1, 3'b001, 5'd7, 7'b0010011), 0, 0, 0);
        chk("R9", "imm f3 001 illegal", {63'b0, illegal}, 64'd1);
    endtask

    task automatic t_bubble;
        issue(0, enc_j(21'd4, 5'd1), 0, 0, 64'h10);
        chk("R10", "bubble valid", {63'b0, out_valid}, 64'd0);
        chk("R10", "bubble taken", {63'b0, taken}, 64'd0);
        chk("R10", "bubble wb", {63'b0, wb_en}, 64'd0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; instr = '0;
        rs1_val = '0; rs2_val = '0; pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_addi();
        t_store();
        t_branch();
        t_jump();
        t_upper();
        t_add();
        t_zero_dest();
        t_illegal();
        t_bubble();
        finish_run();
    end

endmodule